// File: doc/BRIEF.md
# Threshold-Controlled Disk Data FIFO

This block buffers data bytes between a disk data stream and a DMA-style host port. Up to 16 bytes are held in first-in first-out order. A service request tells the host side when to move data. Whether that request rises depends on how full the store is, in read direction, or how empty it is, in write direction, measured against a programmable threshold.

After reset the block acts as a single-byte data register, which keeps the classic one-byte handshake. A configure strobe turns on full FIFO operation and loads a 4-bit threshold field. While a command is being received, the buffering is forced back to single-byte behaviour, so parameter bytes move one at a time. The first cycle of every execution phase empties the store and clears the error flag, so no stale byte reaches the other side. The effective threshold in bytes is available as an output. The host can use it to work out its allowed service latency: threshold × 8 bit-times at the current data rate, less 1.5 µs.

Top module: `dskfifo_top`

## Requirements
- R1: After reset the block is in single-byte mode (`fifo_mode_o`=0), `level_o`=0, `empty_o`=1, `err_o`=0 and `thr_bytes_o`=1.
- R2: In single-byte mode the capacity is one byte: after one accepted push, `full_o`=1 and a second push is not stored.
- R3: A configure strobe (`cfg_stb_i`=1) loads `cfg_fifo_en_i` and `cfg_thr_i`. Outside the command phase with the enable set, `fifo_mode_o`=1 and `thr_bytes_o`=`cfg_thr_i`+1 (field 0 means 1 byte, 15 means 16), clamped to the depth. In single-byte mode `thr_bytes_o`=1.
- R4: While `phase_i`=2'b01 (command), `fifo_mode_o`=0 and the capacity is one byte, whatever the configuration.
- R5: In the first cycle that `phase_i` equals 2'b10 (execution) after any other value, the store is emptied (`level_o`=0 on the next cycle) and `err_o` is cleared. Pushes and pops in that cycle are discarded.
- R6: Bytes leave in the order they were pushed. `rd_data_o` shows the oldest byte without a pop, and the store holds up to 16 bytes in FIFO mode.
- R7: With `dir_rd_i`=1 (data toward the host), `svc_req_o`=1 exactly when `level_o` >= `thr_bytes_o`.
- R8: With `dir_rd_i`=0 (data toward the disk), `svc_req_o`=1 exactly when capacity minus `level_o` >= `thr_bytes_o`.
- R9: A push while `level_o` has reached capacity is dropped, leaves `level_o` unchanged and sets `err_o`.
- R10: A pop while `level_o`=0 leaves `level_o` at 0 and sets `err_o`.
- R11: `err_o` stays set through configure strobes and other phases until the next execution-phase entry.
- R12: A push and a pop in the same cycle with 0 < `level_o` < capacity both take effect and leave `level_o` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| phase_i | input | 2 | Phase: 00 idle, 01 command, 10 execution, 11 result |
| dir_rd_i | input | 1 | 1: data flows to host, 0: data flows to disk |
| cfg_stb_i | input | 1 | Configure strobe |
| cfg_fifo_en_i | input | 1 | FIFO enable carried by the strobe |
| cfg_thr_i | input | 4 | Threshold field carried by the strobe |
| wr_vld_i | input | 1 | Push request |
| wr_data_i | input | 8 | Push data |
| rd_en_i | input | 1 | Pop request |
| rd_data_o | output | 8 | Oldest stored byte |
| level_o | output | 5 | Number of stored bytes |
| empty_o | output | 1 | Store is empty |
| full_o | output | 1 | Level has reached current capacity |
| svc_req_o | output | 1 | Service request to the host side |
| fifo_mode_o | output | 1 | Full FIFO operation in effect |
| thr_bytes_o | output | 5 | Effective threshold in bytes |
| err_o | output | 1 | Sticky overflow/underflow flag |

## Verification
The request logic is tested by filling the store one byte at a time in both directions. The request is sampled at each level, which separates a reach-threshold compare from an off-by-one compare and separates the occupancy rule from the free-space rule. Threshold fields of 3 and 15 separate the "+1" encoding from a raw field. Pushes and pops are run in unconfigured, configured and command-phase settings, which distinguishes the one-byte capacity from the 16-byte capacity. Overflow, underflow, simultaneous push/pop and phase re-entry show whether the error flag, the flush and the level update rules behave as required.

// File: rtl/dskfifo_pkg.sv
package dskfifo_pkg;
  typedef enum logic [1:0] {
    PH_IDLE = 2'b00,
    PH_CMD  = 2'b01,
    PH_EXEC = 2'b10,
    PH_RES  = 2'b11
  } phase_e;
endpackage

// File: rtl/dskfifo_cfg.sv
module dskfifo_cfg #(
  parameter int DEPTH = 16,
  parameter int THR_W = 4,
  localparam int LW = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       phase_i,
  input  logic             cfg_stb_i,
  input  logic             cfg_fifo_en_i,
  input  logic [THR_W-1:0] cfg_thr_i,
  output logic             fifo_act_o,
  output logic [LW-1:0]    cap_o,
  output logic [LW-1:0]    thr_eff_o,
  output logic             flush_o
);
  import dskfifo_pkg::*;

  logic             en_q, en_d;
  logic [THR_W-1:0] thr_q, thr_d;
  phase_e           ph_q, ph_d, ph_cur;
  int               thr_int;

  assign ph_cur = phase_e'(phase_i);

  // next state
  always_comb begin
    en_d  = en_q;
    thr_d = thr_q;
    if (cfg_stb_i) begin
      en_d  = cfg_fifo_en_i;
      thr_d = cfg_thr_i;
    end
    ph_d = ph_cur;
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q  <= 1'b0;
      thr_q <= '0;
      ph_q  <= PH_IDLE;
    end else begin
      en_q  <= en_d;
      thr_q <= thr_d;
      ph_q  <= ph_d;
    end
  end

  assign flush_o    = (ph_cur == PH_EXEC) && (ph_q != PH_EXEC);
  assign fifo_act_o = en_q && (ph_cur != PH_CMD);

  always_comb begin
    thr_int = int'(thr_q) + 1;
    if (thr_int > DEPTH) thr_int = DEPTH;
    if (fifo_act_o) begin
      cap_o     = LW'(DEPTH);
      thr_eff_o = LW'(thr_int);
    end else begin
      cap_o     = LW'(1);
      thr_eff_o = LW'(1);
    end
  end
endmodule

// File: rtl/dskfifo_store.sv
module dskfifo_store #(
  parameter int DEPTH = 16,
  parameter int DW    = 8,
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int LW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush_i,
  input  logic [LW-1:0] cap_i,
  input  logic          push_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          pop_i,
  output logic [DW-1:0] rdata_o,
  output logic [LW-1:0] level_o,
  output logic          err_o
);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  logic [DW-1:0] mem_q [DEPTH];
  logic [AW-1:0] wp_q, wp_d, rp_q, rp_d;
  logic [LW-1:0] lvl_q, lvl_d;
  logic          err_q, err_d;
  logic          push_ok, pop_ok, wr_en;

  assign push_ok = push_i && (lvl_q < cap_i);
  assign pop_ok  = pop_i && (lvl_q != '0);
  assign wr_en   = push_ok && !flush_i;

  // next state
  always_comb begin
    wp_d  = wp_q;
    rp_d  = rp_q;
    lvl_d = lvl_q;
    err_d = err_q;
    if (flush_i) begin
      wp_d  = '0;
      rp_d  = '0;
      lvl_d = '0;
      err_d = 1'b0;
    end else begin
      if (push_ok) wp_d = (wp_q == LAST) ? '0 : wp_q + 1'b1;
      if (pop_ok)  rp_d = (rp_q == LAST) ? '0 : rp_q + 1'b1;
      if (push_ok && !pop_ok)      lvl_d = lvl_q + 1'b1;
      else if (pop_ok && !push_ok) lvl_d = lvl_q - 1'b1;
      if ((push_i && !push_ok) || (pop_i && !pop_ok)) err_d = 1'b1;
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q  <= '0;
      rp_q  <= '0;
      lvl_q <= '0;
      err_q <= 1'b0;
    end else begin
      wp_q  <= wp_d;
      rp_q  <= rp_d;
      lvl_q <= lvl_d;
      err_q <= err_d;
    end
  end

  // storage array, no reset, write enable written out per entry
  for (genvar g = 0; g < DEPTH; g++) begin : g_cell
    always_ff @(posedge clk) begin
      if (wr_en && (wp_q == AW'(g))) mem_q[g] <= wdata_i;
    end
  end

  assign rdata_o = mem_q[rp_q];
  assign level_o = lvl_q;
  assign err_o   = err_q;
endmodule

// File: rtl/dskfifo_req.sv
module dskfifo_req #(
  parameter int DEPTH = 16,
  localparam int LW = $clog2(DEPTH + 1)
) (
  input  logic          dir_rd_i,
  input  logic [LW-1:0] level_i,
  input  logic [LW-1:0] cap_i,
  input  logic [LW-1:0] thr_i,
  output logic          svc_o,
  output logic          full_o
);
  logic [LW-1:0] free_room;

  always_comb begin
    free_room = (level_i < cap_i) ? (cap_i - level_i) : '0;
    full_o    = (level_i >= cap_i);
    if (dir_rd_i) svc_o = (level_i >= thr_i);
    else          svc_o = (free_room >= thr_i);
  end
endmodule

// File: rtl/dskfifo_top.sv
module dskfifo_top #(
  parameter int DEPTH = 16,
  parameter int DW    = 8,
  parameter int THR_W = 4,
  localparam int LW = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       phase_i,
  input  logic             dir_rd_i,
  input  logic             cfg_stb_i,
  input  logic             cfg_fifo_en_i,
  input  logic [THR_W-1:0] cfg_thr_i,
  input  logic             wr_vld_i,
  input  logic [DW-1:0]    wr_data_i,
  input  logic             rd_en_i,
  output logic [DW-1:0]    rd_data_o,
  output logic [LW-1:0]    level_o,
  output logic             empty_o,
  output logic             full_o,
  output logic             svc_req_o,
  output logic             fifo_mode_o,
  output logic [LW-1:0]    thr_bytes_o,
  output logic             err_o
);
  logic          fifo_act, flush;
  logic [LW-1:0] cap, thr_eff, lvl;

  dskfifo_cfg #(.DEPTH(DEPTH), .THR_W(THR_W)) cfg_i (
    .clk(clk), .rst_n(rst_n), .phase_i(phase_i),
    .cfg_stb_i(cfg_stb_i), .cfg_fifo_en_i(cfg_fifo_en_i), .cfg_thr_i(cfg_thr_i),
    .fifo_act_o(fifo_act), .cap_o(cap), .thr_eff_o(thr_eff), .flush_o(flush)
  );

  dskfifo_store #(.DEPTH(DEPTH), .DW(DW)) store_i (
    .clk(clk), .rst_n(rst_n), .flush_i(flush), .cap_i(cap),
    .push_i(wr_vld_i), .wdata_i(wr_data_i), .pop_i(rd_en_i),
    .rdata_o(rd_data_o), .level_o(lvl), .err_o(err_o)
  );

  dskfifo_req #(.DEPTH(DEPTH)) req_i (
    .dir_rd_i(dir_rd_i), .level_i(lvl), .cap_i(cap), .thr_i(thr_eff),
    .svc_o(svc_req_o), .full_o(full_o)
  );

  assign level_o     = lvl;
  assign empty_o     = (lvl == '0);
  assign fifo_mode_o = fifo_act;
  assign thr_bytes_o = thr_eff;
endmodule

// File: rtl/dskfifo_chk.sv
module dskfifo_chk #(
  parameter int DEPTH = 16,
  localparam int LW = $clog2(DEPTH + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic [1:0]    phase_i,
  input logic          dir_rd_i,
  input logic          wr_vld_i,
  input logic          rd_en_i,
  input logic [LW-1:0] level_o,
  input logic          empty_o,
  input logic          full_o,
  input logic          svc_req_o,
  input logic          fifo_mode_o,
  input logic [LW-1:0] thr_bytes_o,
  input logic          err_o
);
  AST_CMD_BYTE_MODE: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_i == 2'b01) |-> !fifo_mode_o); // R4
  AST_EXEC_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_i == 2'b10 && $past(phase_i) != 2'b10) |=> (level_o == '0 && !err_o)); // R5
  AST_LEVEL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    level_o <= LW'(DEPTH)); // R6
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_vld_i && !rd_en_i && full_o && phase_i != 2'b10) |=> (err_o && $stable(level_o))); // R9
  AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en_i && !wr_vld_i && empty_o && phase_i != 2'b10) |=> (err_o && level_o == '0)); // R10
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (err_o && phase_i != 2'b10) |=> err_o); // R11
  AST_SVC_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (dir_rd_i && level_o >= thr_bytes_o) |-> svc_req_o); // R7
  AST_THR_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (thr_bytes_o >= LW'(1) && thr_bytes_o <= LW'(DEPTH))); // R3
endmodule

bind dskfifo_top dskfifo_chk #(.DEPTH(DEPTH)) chk_i (
  .clk(clk), .rst_n(rst_n), .phase_i(phase_i), .dir_rd_i(dir_rd_i),
  .wr_vld_i(wr_vld_i), .rd_en_i(rd_en_i), .level_o(level_o),
  .empty_o(empty_o), .full_o(full_o), .svc_req_o(svc_req_o),
  .fifo_mode_o(fifo_mode_o), .thr_bytes_o(thr_bytes_o), .err_o(err_o)
);

// File: tb/dskfifo_top_tb_top.sv
`timescale 1ns/1ps
module dskfifo_top_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] phase_i = 2'b00;
  logic       dir_rd_i = 1'b0;
  logic       cfg_stb_i = 1'b0;
  logic       cfg_fifo_en_i = 1'b0;
  logic [3:0] cfg_thr_i = 4'd0;
  logic       wr_vld_i = 1'b0;
  logic [7:0] wr_data_i = 8'd0;
  logic       rd_en_i = 1'b0;
  logic [7:0] rd_data_o;
  logic [4:0] level_o, thr_bytes_o;
  logic       empty_o, full_o, svc_req_o, fifo_mode_o, err_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  dskfifo_top dut_i (
    .clk(clk), .rst_n(rst_n), .phase_i(phase_i), .dir_rd_i(dir_rd_i),
    .cfg_stb_i(cfg_stb_i), .cfg_fifo_en_i(cfg_fifo_en_i), .cfg_thr_i(cfg_thr_i),
    .wr_vld_i(wr_vld_i), .wr_data_i(wr_data_i), .rd_en_i(rd_en_i),
    .rd_data_o(rd_data_o), .level_o(level_o), .empty_o(empty_o), .full_o(full_o),
    .svc_req_o(svc_req_o), .fifo_mode_o(fifo_mode_o), .thr_bytes_o(thr_bytes_o),
    .err_o(err_o)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic push(input logic [7:0] d);
    wr_vld_i = 1'b1; wr_data_i = d;
    step();
    wr_vld_i = 1'b0;
  endtask

  task automatic pop_expect(input string req, input logic [7:0] d);
    chk(req, int'(rd_data_o), int'(d));
    rd_en_i = 1'b1;
    step();
    rd_en_i = 1'b0;
  endtask

  task automatic configure(input logic en, input logic [3:0] thr);
    cfg_stb_i = 1'b1; cfg_fifo_en_i = en; cfg_thr_i = thr;
    step();
    cfg_stb_i = 1'b0;
  endtask

  task automatic enter_exec();
    phase_i = 2'b11; step();
    phase_i = 2'b10; step();
  endtask

  task automatic t_reset();
    chk("R1 mode", int'(fifo_mode_o), 0);
    chk("R1 level", int'(level_o), 0);
    chk("R1 empty", int'(empty_o), 1);
    chk("R1 err", int'(err_o), 0);
    chk("R1 thr", int'(thr_bytes_o), 1);
    chk("R8 svc write empty", int'(svc_req_o), 1);
  endtask

  task automatic t_byte_mode();
    push(8'h3C);
    chk("R2 full", int'(full_o), 1);
    chk("R8 svc write full", int'(svc_req_o), 0);
    dir_rd_i = 1'b1; #1;
    chk("R7 svc read one", int'(svc_req_o), 1);
    push(8'h77);
    chk("R9 level held", int'(level_o), 1);
    chk("R9 err", int'(err_o), 1);
    pop_expect("R2 data", 8'h3C);
    chk("R2 level", int'(level_o), 0);
    configure(1'b0, 4'd2);
    phase_i = 2'b11; step();
    chk("R11 err sticky", int'(err_o), 1);
    phase_i = 2'b10; step();
    chk("R5 err cleared", int'(err_o), 0);
    chk("R5 level", int'(level_o), 0);
  endtask

  task automatic t_cmd_phase();
    configure(1'b1, 4'd3);
    chk("R3 mode", int'(fifo_mode_o), 1);
    chk("R3 thr", int'(thr_bytes_o), 4);
    phase_i = 2'b01; #1;
    chk("R4 mode", int'(fifo_mode_o), 0);
    chk("R3 thr byte", int'(thr_bytes_o), 1);
    push(8'h01);
    chk("R4 full", int'(full_o), 1);
    push(8'h02);
    chk("R4 capacity", int'(level_o), 1);
    phase_i = 2'b10; step();
    chk("R5 flush level", int'(level_o), 0);
    chk("R5 flush err", int'(err_o), 0);
    chk("R3 mode exec", int'(fifo_mode_o), 1);
  endtask

  task automatic t_read_fill();
    dir_rd_i = 1'b1;
    for (int i = 0; i < 16; i++) begin
      push(8'h10 + 8'(i));
      chk("R7 svc read", int'(svc_req_o), (i + 1 >= 4) ? 1 : 0);
    end
    chk("R6 full 16", int'(full_o), 1);
    push(8'hEE);
    chk("R9 level 16", int'(level_o), 16);
    chk("R9 err fifo", int'(err_o), 1);
    for (int i = 0; i < 16; i++) pop_expect("R6 order", 8'h10 + 8'(i));
    chk("R6 empty", int'(empty_o), 1);
    enter_exec();
    rd_en_i = 1'b1; step(); rd_en_i = 1'b0;
    chk("R10 level", int'(level_o), 0);
    chk("R10 err", int'(err_o), 1);
  endtask

  task automatic t_write_fill();
    enter_exec();
    dir_rd_i = 1'b0; #1;
    chk("R8 svc empty", int'(svc_req_o), 1);
    for (int i = 0; i < 16; i++) begin
      push(8'h40 + 8'(i));
      chk("R8 svc write", int'(svc_req_o), (16 - (i + 1) >= 4) ? 1 : 0);
    end
  endtask

  task automatic t_both();
    enter_exec();
    for (int i = 0; i < 5; i++) push(8'h80 + 8'(i));
    chk("R12 head", int'(rd_data_o), 8'h80);
    wr_vld_i = 1'b1; wr_data_i = 8'hA5; rd_en_i = 1'b1;
    step();
    wr_vld_i = 1'b0; rd_en_i = 1'b0;
    chk("R12 level", int'(level_o), 5);
    chk("R12 err", int'(err_o), 0);
    for (int i = 1; i < 5; i++) pop_expect("R12 order", 8'h80 + 8'(i));
    pop_expect("R12 new byte", 8'hA5);
  endtask

  task automatic t_thr_max();
    configure(1'b1, 4'd15);
    chk("R3 thr max", int'(thr_bytes_o), 16);
    dir_rd_i = 1'b1;
    for (int i = 0; i < 16; i++) push(8'(i));
    chk("R7 svc at 16", int'(svc_req_o), 1);
    pop_expect("R7 pop", 8'h00);
    chk("R7 svc at 15", int'(svc_req_o), 0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    #1;
    t_reset();
    t_byte_mode();
    t_cmd_phase();
    t_read_fill();
    t_write_fill();
    t_both();
    t_thr_max();
    done = 1'b1;
  end

  initial begin
    fork
      begin wait (done); end
      begin
        repeat (5000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog actual=0 expected=1");
      end
    join_any
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule